// File: doc/BRIEF.md
# I2C Incomplete-Write Fault Injector

This block is a small bit-level I2C controller that drives a bus into a deliberately broken state in order to exercise bus-recovery logic elsewhere in a system. After a start pulse with a 7-bit target address, it opens a write transaction to that target and checks whether the address is acknowledged. If it is, the block clocks out a single zero byte. It then stops inside the acknowledge clock of that byte. Because the target is still acknowledging, it keeps SDA low. It is also now primed to write to its register zero if any more clocks arrive.

The two bus pins are open-drain. The block only produces pull-low enables and never drives a line high. It watches the resolved line levels through a short synchronizer. Every low and high half-period of SCL lasts a fixed number of system clocks, set by a parameter. An unacknowledged address is closed cleanly with a STOP and reported through a status flag.

Top module: `i2c_wr_stall_injector`

## Requirements
- R1: In reset and right after it, both pull enables are 0 and busy, done and addr_nack are all 0.
- R2: A go pulse starts a transaction only when the block is idle and both synchronized lines read high. A go pulse while busy, or while either line is low, has no effect.
- R3: A transaction opens with a START: SDA is pulled low while SCL is released, and SCL is pulled low one phase later.
- R4: The first byte on the bus is the 7-bit target address, MSB first, followed by a write bit of 0. The target therefore receives {tgt_addr, 1'b0}.
- R5: Apart from the START and STOP edges, SDA changes only while SCL is low.
- R6: Each SCL low phase and each completed SCL high phase lasts exactly PHASE_CLKS system clocks.
- R7: When the address is acknowledged (SDA low at the ninth clock), exactly one data byte of 0x00 follows, MSB first.
- R8: After the eighth data bit, SDA is released, SCL is released for the ninth clock, and the block halts there. There are no further SCL edges and no STOP. Both pull enables end at 0, and done pulses while busy falls. The target's acknowledge keeps SDA low, so a complete run shows 18 SCL rising edges.
- R9: When the address is not acknowledged (SDA high at its ninth clock), the block issues a STOP (SDA rising while SCL is high) and sets addr_nack. No data byte is sent, so the run shows 10 SCL rising edges.
- R10: done is a single-cycle pulse. addr_nack keeps its value after done until the next accepted go, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, sampled with tgt_addr |
| tgt_addr | input | ADDR_W | 7-bit target address |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when the transaction ends |
| addr_nack | output | 1 | Address was not acknowledged in the last run |

## Verification
The assertions check several properties on every cycle:
- SDA is held steady through each SCL high phase.
- The phase counter stays within its range and decrements by one.
- A transaction starts only from a legal go with the START drive pattern.
- done is a single-cycle pulse with both lines released.
- A STOP happens only after a NACK, and no data byte follows a NACK.

The bench scenarios show what no single-cycle property can see: the bytes the target actually decodes, the exact count of SCL rising edges, the absence of a STOP after the halt, the measured phase lengths, and the target left holding SDA low. A bus model with an addressable target records these. The bench also shows that go is ignored while the bus is held low or a run is already in progress.

// File: rtl/i2c_wsi_pkg.sv
package i2c_wsi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOW,
    ST_HIGH,
    ST_STOP_LO,
    ST_STOP_HI
  } seq_state_t;

  localparam logic [7:0] FILL_BYTE = 8'h00;
  localparam logic       WRITE_DIR = 1'b0;
  localparam int         ACK_SLOT  = 8;
endpackage

// File: rtl/i2c_wsi_sync.sv
module i2c_wsi_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '1;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '1;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_wsi_phase_timer.sv
module i2c_wsi_phase_timer #(
  parameter int PHASE_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt <= LOAD;
    else                       cnt <= cnt - 1'b1;
  end

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD);

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !expire) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/i2c_wsi_sequencer.sv
module i2c_wsi_sequencer
  import i2c_wsi_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              tick,
  output logic              busy,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              done,
  output logic              addr_nack
);
  localparam int FRAME_W = ADDR_W + 1;
  localparam int BC_W    = $clog2(ACK_SLOT + 1);
  localparam logic [BC_W-1:0] LAST_DATA = BC_W'(ACK_SLOT - 1);
  localparam logic [BC_W-1:0] ACK_POS   = BC_W'(ACK_SLOT);

  seq_state_t        st;
  logic [FRAME_W-1:0] shreg;
  logic [BC_W-1:0]    bitcnt;
  logic               data_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      data_phase <= 1'b0;
      busy       <= 1'b0;
      scl_pull   <= 1'b0;
      sda_pull   <= 1'b0;
      done       <= 1'b0;
      addr_nack  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go && scl_s && sda_s) begin
            st         <= ST_START;
            shreg      <= {addr, WRITE_DIR};
            bitcnt     <= '0;
            data_phase <= 1'b0;
            sda_pull   <= 1'b1;
            busy       <= 1'b1;
            addr_nack  <= 1'b0;
          end
        end
        ST_START: begin
          if (tick) begin
            st       <= ST_LOW;
            scl_pull <= 1'b1;
            sda_pull <= ~shreg[FRAME_W-1];
          end
        end
        ST_LOW: begin
          if (tick) begin
            st       <= ST_HIGH;
            scl_pull <= 1'b0;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            if (bitcnt != ACK_POS) begin
              bitcnt   <= bitcnt + 1'b1;
              shreg    <= {shreg[FRAME_W-2:0], 1'b0};
              st       <= ST_LOW;
              scl_pull <= 1'b1;
              sda_pull <= (bitcnt == LAST_DATA) ? 1'b0 : ~shreg[FRAME_W-2];
            end else if (!data_phase) begin
              if (sda_s) begin
                addr_nack <= 1'b1;
                st        <= ST_STOP_LO;
                scl_pull  <= 1'b1;
                sda_pull  <= 1'b1;
              end else begin
                data_phase <= 1'b1;
                bitcnt     <= '0;
                shreg      <= FRAME_W'(FILL_BYTE);
                st         <= ST_LOW;
                scl_pull   <= 1'b1;
                sda_pull   <= ~FILL_BYTE[7];
              end
            end else begin
              st       <= ST_IDLE;
              busy     <= 1'b0;
              done     <= 1'b1;
              sda_pull <= 1'b0;
              scl_pull <= 1'b0;
            end
          end
        end
        ST_STOP_LO: begin
          if (tick) begin
            st       <= ST_STOP_HI;
            scl_pull <= 1'b0;
          end
        end
        ST_STOP_HI: begin
          if (tick) begin
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: SDA holds through an SCL high phase
  assert_sda_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HIGH && !tick) |=> $stable(sda_pull));

  assert_start_shape_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (sda_pull && !scl_pull));

  assert_go_guard_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go && scl_s && sda_s));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_released_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !scl_pull && !sda_pull));

  assert_stop_after_nack_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP_LO) |-> addr_nack);

  assert_no_data_after_nack_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && addr_nack) |-> !data_phase);
endmodule

// File: rtl/i2c_wr_stall_injector.sv
module i2c_wr_stall_injector #(
  parameter int ADDR_W      = 7,
  parameter int PHASE_CLKS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              busy,
  output logic              done,
  output logic              addr_nack
);
  logic [1:0] lines_s;
  logic       tick;

  i2c_wsi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (lines_s)
  );

  i2c_wsi_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (busy),
    .expire (tick)
  );

  i2c_wsi_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .addr      (tgt_addr),
    .scl_s     (lines_s[1]),
    .sda_s     (lines_s[0]),
    .tick      (tick),
    .busy      (busy),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .done      (done),
    .addr_nack (addr_nack)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!scl_pull && !sda_pull && !busy && !done && !addr_nack));
endmodule

// File: tb/i2c_wr_stall_injector_tb.sv
module i2c_wr_stall_injector_tb;
  localparam int DIV = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [6:0] tgt_addr = '0;
  logic scl_pull, sda_pull, busy, done, addr_nack;
  logic tgt_low = 1'b0;
  logic force_low = 1'b0;
  logic clr_req = 1'b0;
  logic [6:0] my_addr = 7'h55;

  wire scl_line = !scl_pull;
  wire sda_line = !(sda_pull || tgt_low || force_low);

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  i2c_wr_stall_injector #(.ADDR_W(7), .PHASE_CLKS(DIV), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .go(go), .tgt_addr(tgt_addr),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .busy(busy), .done(done), .addr_nack(addr_nack)
  );

  // target / bus monitor
  logic prev_scl, prev_sda, in_frame, addressed;
  int bitpos, nbytes, rises, starts, stops, hl_events, lo_len, hi_len, lo_bad, hi_bad;
  logic [7:0] cur_byte;
  logic [7:0] rx0, rx1;

  always @(negedge clk) begin
    if (rst || clr_req) begin
      prev_scl = 1'b1; prev_sda = 1'b1; in_frame = 1'b0; addressed = 1'b0;
      bitpos = 0; nbytes = 0; rises = 0; starts = 0; stops = 0; hl_events = 0;
      lo_len = 0; hi_len = 0; lo_bad = 0; hi_bad = 0; cur_byte = '0;
      rx0 = 8'hxx; rx1 = 8'hxx; tgt_low = 1'b0;
    end else begin
      if (prev_scl && scl_line && (prev_sda != sda_line)) begin
        hl_events++;
        if (!sda_line) begin
          starts++; in_frame = 1'b1; bitpos = 0; cur_byte = '0;
        end else begin
          stops++; in_frame = 1'b0;
        end
      end
      if (!prev_scl && scl_line) begin
        rises++;
        if (in_frame && lo_len != DIV) lo_bad++;
        if (in_frame && bitpos < 8) cur_byte = {cur_byte[6:0], sda_line};
        bitpos++;
        hi_len = 1;
      end else if (prev_scl && !scl_line) begin
        if (in_frame && rises > 0 && hi_len != DIV) hi_bad++;
        if (in_frame && bitpos == 8) begin
          if (nbytes == 0) begin
            rx0 = cur_byte;
            addressed = (cur_byte[7:1] == my_addr);
          end else begin
            rx1 = cur_byte;
          end
          nbytes++;
          if (addressed) tgt_low = 1'b1;
        end else if (bitpos == 9) begin
          tgt_low = 1'b0; bitpos = 0; cur_byte = '0;
        end
        lo_len = 1;
      end else if (scl_line) begin
        hi_len++;
      end else begin
        lo_len++;
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
    end
  end

  function automatic logic [7:0] exp_first_byte(input logic [6:0] a);
    return {a, 1'b0};
  endfunction

  function automatic int exp_rises(input bit acked);
    return acked ? 18 : 10;
  endfunction

  function automatic int exp_events(input bit acked);
    return acked ? 1 : 2;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_bus();
    @(posedge clk); #1 clr_req = 1'b1;
    @(posedge clk); #1 clr_req = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  task automatic pulse_go(input logic [6:0] a);
    @(posedge clk); #1 go = 1'b1; tgt_addr = a;
    @(posedge clk); #1 go = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic run_txn(input logic [6:0] a, input bit acked, input bit mid_go);
    bit seen;
    my_addr = acked ? a : (a ^ 7'h2A);
    clear_bus();
    pulse_go(a);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R2 go accepted busy", int'(busy), 1);
    check(addr_nack == 1'b0, "R10 nack cleared by go", int'(addr_nack), 0);
    if (mid_go) begin
      repeat (3 * DIV) @(posedge clk);
      pulse_go(~a);
    end
    wait_done(seen);
    check(seen, "R8 done pulse seen", int'(seen), 1);
    check(busy == 1'b0, "R8 busy low at done", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", int'(done), 0);
    repeat (3 * DIV) @(negedge clk);
    check(addr_nack == !acked, "R9 addr_nack status", int'(addr_nack), int'(!acked));
    check(!scl_pull && !sda_pull, "R8 pulls released", int'({scl_pull, sda_pull}), 0);
    check(starts == 1, "R3 single START", starts, 1);
    check(rx0 == exp_first_byte(a), "R4 address byte", int'(rx0), int'(exp_first_byte(a)));
    check(rises == exp_rises(acked), "R8 SCL rising edges", rises, exp_rises(acked));
    check(hl_events == exp_events(acked), "R5 SDA edges while SCL high", hl_events, exp_events(acked));
    check(lo_bad == 0 && hi_bad == 0, "R6 phase lengths", lo_bad + hi_bad, 0);
    if (acked) begin
      check(nbytes == 2 && rx1 == 8'h00, "R7 zero data byte", int'(rx1), 0);
      check(stops == 0, "R8 no STOP after halt", stops, 0);
      check(scl_line == 1'b1 && sda_line == 1'b0, "R8 SCL high SDA held low",
            int'({scl_line, sda_line}), 2);
    end else begin
      check(stops == 1, "R9 STOP issued", stops, 1);
      check(nbytes == 1, "R9 no data byte", nbytes, 1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1DC0FFEE));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!scl_pull && !sda_pull && !busy && !done && !addr_nack, "R1 state during reset",
          int'({scl_pull, sda_pull, busy, done, addr_nack}), 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!scl_pull && !sda_pull && !busy && !done && !addr_nack, "R1 state after reset",
          int'({scl_pull, sda_pull, busy, done, addr_nack}), 0);

    // R2: go ignored while SDA is held low by another party
    clear_bus();
    force_low = 1'b1;
    repeat (4) @(posedge clk);
    pulse_go(7'h33);
    repeat (8 * DIV) @(negedge clk);
    check(busy == 1'b0 && rises == 0, "R2 go ignored with bus low", int'(busy) + rises, 0);
    force_low = 1'b0;

    // directed corners
    run_txn(7'h50, 1'b1, 1'b0);
    run_txn(7'h7F, 1'b1, 1'b1);   // R2: mid-run go ignored
    run_txn(7'h00, 1'b0, 1'b0);
    // R10: nack held until next accepted go
    repeat (20) @(negedge clk);
    check(addr_nack == 1'b1, "R10 nack held while idle", int'(addr_nack), 1);
    run_txn(7'h01, 1'b1, 1'b0);

    // random mix
    for (int n = 0; n < 16; n++) begin
      logic [6:0] ra;
      bit ack;
      ra  = 7'($urandom);
      ack = ($urandom % 3) != 0;
      run_txn(ra, ack, ($urandom % 4) == 0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule